// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This block is the hazard logic of a five-stage in-order integer pipeline. The stages are fetch, decode with register read, execute, memory access and write back. Every instruction visits every stage. Operands are read in the second stage and results are written in the fifth, so writes always happen in program order. Read-after-write is therefore the only dependency the block has to resolve. For each of the two ALU inputs of the instruction in execute, it compares the source register number against the destination held in the execute/memory latch and the memory/writeback latch. It then drives the select of a three-way operand multiplexer: register-file value, execute/memory result, or memory/writeback result. When both latches hold the needed register, the younger result, in execute/memory, wins.

A load's data is not available until the end of the memory stage. An instruction that reads the loaded register directly after the load therefore cannot be bypassed in time. The unit detects this case in the decode stage and asserts three controls: hold the PC, hold the fetch/decode latch, and load a bubble into the decode/execute latch. On the next cycle the bubble occupies execute and selects no bypass. One cycle later the dependent instruction reaches execute and takes the load data from memory/writeback.

The register file writes in the first half of the cycle and reads in the second half. A decode-stage read therefore already sees a value being written back, and the unit has no writeback-to-decode path. The unit is purely combinational. Its outputs depend only on the latch fields presented in the current cycle.

Top module: `bypass_interlock_unit`

## Requirements
- R1: An operand select is 2'b01 (execute/memory result) when that latch has its write enable high, its destination is non-zero and its destination equals the operand's source register.
- R2: An operand select is 2'b10 (memory/writeback result) when only the memory/writeback latch meets the same conditions (write enable high, non-zero destination equal to the source).
- R3: When both latches meet the conditions for the same source, the select is 2'b01.
- R4: A destination of register 0, or a latch whose write enable is low, never causes a select other than 2'b00 and never causes a stall.
- R5: With no qualifying match, the select is 2'b00 (register-file value). The code 2'b11 is never driven.
- R6: When the decode/execute latch holds a bubble (ex_valid low), both selects are 2'b00 whatever the latch fields hold.
- R7: When the decode/execute latch holds a load (idex_load and idex_we high) whose non-zero destination equals either decode-stage source, pc_hold, ifid_hold and idex_bubble are all 1 in that cycle.
- R8: A non-load instruction in decode/execute whose destination matches a decode-stage source causes no stall, because bypassing covers it.
- R9: The two operand selects are independent: each depends only on its own source register.
- R10: A memory/writeback or execute/memory destination matching a decode-stage source causes no stall, because the split-phase register file makes no writeback-to-decode bypass necessary.
- R11: In a load, bubble, dependent sequence, the stall is 1 only in the first cycle, both selects are 2'b00 on the bubble, and the dependent operand selects 2'b10 when it reaches execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | AW | First source register of the instruction in decode |
| id_rs2 | input | AW | Second source register of the instruction in decode |
| ex_valid | input | 1 | Decode/execute latch holds a real instruction (low for a bubble) |
| ex_rs1 | input | AW | First source register held in the decode/execute latch |
| ex_rs2 | input | AW | Second source register held in the decode/execute latch |
| idex_rd | input | AW | Destination register held in the decode/execute latch |
| idex_we | input | 1 | Register-write enable in the decode/execute latch |
| idex_load | input | 1 | Decode/execute latch holds a load |
| exmem_rd | input | AW | Destination register in the execute/memory latch |
| exmem_we | input | 1 | Register-write enable in the execute/memory latch |
| memwb_rd | input | AW | Destination register in the memory/writeback latch |
| memwb_we | input | 1 | Register-write enable in the memory/writeback latch |
| fwd_a | output | 2 | Select for ALU input A: 00 register file, 01 execute/memory, 10 memory/writeback |
| fwd_b | output | 2 | Select for ALU input B, same encoding |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode latch unchanged this cycle |
| idex_bubble | output | 1 | Clear the decode/execute control fields to a no-op this cycle |

## Verification
Every output of this unit is combinational, so each select and each stall control is due in the same cycle in which the latch fields are presented, with no register in between. The bench changes the inputs just after a falling clock edge and samples one nanosecond later, well before the next rising edge. The load, bubble, dependent sequence is played one latch snapshot per cycle. The stall is expected only in the first snapshot, no bypass on the bubble, and a memory/writeback select in the third.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

    // Operand source select codes seen by the ALU input multiplexers
    typedef enum logic [1:0] {
        OPSRC_REGFILE = 2'b00,
        OPSRC_EXMEM   = 2'b01,
        OPSRC_MEMWB   = 2'b10
    } opsrc_e;

    // Controls the interlock sends to the front of the pipeline
    typedef struct packed {
        logic hold_pc;
        logic hold_ifid;
        logic bubble_idex;
    } stall_ctl_t;

    localparam stall_ctl_t STALL_NONE = '{hold_pc: 1'b0, hold_ifid: 1'b0, bubble_idex: 1'b0};
    localparam stall_ctl_t STALL_ALL  = '{hold_pc: 1'b1, hold_ifid: 1'b1, bubble_idex: 1'b1};

endpackage

// File: rtl/producer_qual.sv
// A latch counts as a producer only if it writes a real (non-zero) register.
module producer_qual #(
    parameter int AW = 5
) (
    input  logic          we,
    input  logic [AW-1:0] rd,
    output logic          live
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    always_comb begin
        live = we && (rd != ZERO_REG);
    end
endmodule

// File: rtl/operand_select.sv
module operand_select
    import bypass_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          valid,
    input  logic [AW-1:0] src,
    input  logic          exm_live,
    input  logic [AW-1:0] exm_rd,
    input  logic          mwb_live,
    input  logic [AW-1:0] mwb_rd,
    output opsrc_e        sel
);
    logic hit_exm;
    logic hit_mwb;

    always_comb begin
        hit_exm = valid && exm_live && (exm_rd == src);
        hit_mwb = valid && mwb_live && (mwb_rd == src);
        // younger result (execute/memory) takes priority
        if (hit_exm)      sel = OPSRC_EXMEM;
        else if (hit_mwb) sel = OPSRC_MEMWB;
        else              sel = OPSRC_REGFILE;
    end

    always_comb begin
        if (sel == OPSRC_MEMWB) begin
            assert_memwb_not_shadowed_R3: assert (!(exm_live && exm_rd == src))
                else $error("memwb chosen while exmem also matches");
        end
    end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect
    import bypass_pkg::*;
#(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC*AW-1:0] id_srcs,
    input  logic               ld_live,
    input  logic               ld_is_load,
    input  logic [AW-1:0]      ld_rd,
    output stall_ctl_t         ctl
);
    logic [NSRC-1:0] src_hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign src_hit[i] = (id_srcs[i*AW +: AW] == ld_rd);
    end

    logic need_stall;

    always_comb begin
        need_stall = ld_live && ld_is_load && (|src_hit);
        ctl = need_stall ? STALL_ALL : STALL_NONE;
    end
endmodule

// File: rtl/bypass_interlock_unit.sv
module bypass_interlock_unit
    import bypass_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          ex_valid,
    input  logic [AW-1:0] ex_rs1,
    input  logic [AW-1:0] ex_rs2,
    input  logic [AW-1:0] idex_rd,
    input  logic          idex_we,
    input  logic          idex_load,
    input  logic [AW-1:0] exmem_rd,
    input  logic          exmem_we,
    input  logic [AW-1:0] memwb_rd,
    input  logic          memwb_we,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          idex_bubble
);
    localparam int NOPS = 2;

    logic idex_live;
    logic exmem_live;
    logic memwb_live;

    producer_qual #(.AW(AW)) u_q_idex  (.we(idex_we),  .rd(idex_rd),  .live(idex_live));
    producer_qual #(.AW(AW)) u_q_exmem (.we(exmem_we), .rd(exmem_rd), .live(exmem_live));
    producer_qual #(.AW(AW)) u_q_memwb (.we(memwb_we), .rd(memwb_rd), .live(memwb_live));

    logic [AW-1:0] ex_src [NOPS];
    opsrc_e        op_sel [NOPS];

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    for (genvar k = 0; k < NOPS; k++) begin : g_op
        operand_select #(.AW(AW)) u_sel (
            .valid    (ex_valid),
            .src      (ex_src[k]),
            .exm_live (exmem_live),
            .exm_rd   (exmem_rd),
            .mwb_live (memwb_live),
            .mwb_rd   (memwb_rd),
            .sel      (op_sel[k])
        );
    end

    stall_ctl_t ctl;

    load_use_detect #(.AW(AW), .NSRC(NOPS)) u_lu (
        .id_srcs    ({id_rs2, id_rs1}),
        .ld_live    (idex_live),
        .ld_is_load (idex_load),
        .ld_rd      (idex_rd),
        .ctl        (ctl)
    );

    assign fwd_a       = op_sel[0];
    assign fwd_b       = op_sel[1];
    assign pc_hold     = ctl.hold_pc;
    assign ifid_hold   = ctl.hold_ifid;
    assign idex_bubble = ctl.bubble_idex;

    always_comb begin
        assert_legal_code_R5: assert (fwd_a != 2'b11 && fwd_b != 2'b11)
            else $error("illegal select code");
        if (!ex_valid) begin
            assert_bubble_quiet_R6: assert (fwd_a == 2'b00 && fwd_b == 2'b00)
                else $error("bypass selected for a bubble");
        end
        if (fwd_a == 2'b10 || fwd_b == 2'b10) begin
            assert_zero_never_R4: assert (memwb_we && memwb_rd != '0)
                else $error("memwb bypass from dead producer");
        end
        if (pc_hold) begin
            assert_stall_needs_load_R8: assert (idex_load && idex_we && idex_rd != '0)
                else $error("stall without a live load");
        end
        assert_stall_together_R7: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble)
            else $error("stall controls disagree");
    end
endmodule

// File: tb/sim_bypass_interlock_unit.sv
module sim_bypass_interlock_unit;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, idex_rd, exmem_rd, memwb_rd;
    logic ex_valid, idex_we, idex_load, exmem_we, memwb_we;
    logic [1:0] fwd_a, fwd_b;
    logic pc_hold, ifid_hold, idex_bubble;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bypass_interlock_unit #(.AW(AW)) u0 (
        .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_valid(ex_valid),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .idex_rd(idex_rd), .idex_we(idex_we), .idex_load(idex_load),
        .exmem_rd(exmem_rd), .exmem_we(exmem_we),
        .memwb_rd(memwb_rd), .memwb_we(memwb_we),
        .fwd_a(fwd_a), .fwd_b(fwd_b),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_stall(input string req, input int exp);
        chk(req, {29'd0, pc_hold, ifid_hold, idex_bubble}, exp ? 7 : 0);
    endtask

    // all latches empty, sources on distinct registers
    task automatic quiet();
        @(negedge clk);
        id_rs1 = 5'd20; id_rs2 = 5'd21;
        ex_valid = 1'b1; ex_rs1 = 5'd1; ex_rs2 = 5'd2;
        idex_rd = 5'd0; idex_we = 1'b0; idex_load = 1'b0;
        exmem_rd = 5'd0; exmem_we = 1'b0;
        memwb_rd = 5'd0; memwb_we = 1'b0;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset_state();
        quiet(); settle();
        chk("R5 idle fwd_a", fwd_a, 0);
        chk("R5 idle fwd_b", fwd_b, 0);
        chk_stall("R5 idle stall", 0);
    endtask

    task automatic t_exmem();
        quiet(); exmem_rd = 5'd1; exmem_we = 1'b1; settle();
        chk("R1 exmem on A", fwd_a, 1);
        chk("R9 B untouched", fwd_b, 0);
        quiet(); exmem_rd = 5'd2; exmem_we = 1'b1; settle();
        chk("R1 exmem on B", fwd_b, 1);
        chk("R9 A untouched", fwd_a, 0);
    endtask

    task automatic t_memwb();
        quiet(); memwb_rd = 5'd2; memwb_we = 1'b1; settle();
        chk("R2 memwb on B", fwd_b, 2);
        chk("R2 A regfile", fwd_a, 0);
        quiet(); memwb_rd = 5'd1; memwb_we = 1'b1; exmem_rd = 5'd2; exmem_we = 1'b1; settle();
        chk("R9 A memwb", fwd_a, 2);
        chk("R9 B exmem", fwd_b, 1);
    endtask

    task automatic t_priority();
        quiet(); exmem_rd = 5'd1; exmem_we = 1'b1; memwb_rd = 5'd1; memwb_we = 1'b1; settle();
        chk("R3 both match A", fwd_a, 1);
        quiet(); ex_rs1 = 5'd7; ex_rs2 = 5'd7;
        exmem_rd = 5'd7; exmem_we = 1'b1; memwb_rd = 5'd7; memwb_we = 1'b1; settle();
        chk("R3 both match A same src", fwd_a, 1);
        chk("R3 both match B same src", fwd_b, 1);
    endtask

    task automatic t_dead_producers();
        quiet(); ex_rs1 = 5'd0; ex_rs2 = 5'd0;
        exmem_rd = 5'd0; exmem_we = 1'b1; memwb_rd = 5'd0; memwb_we = 1'b1; settle();
        chk("R4 r0 A", fwd_a, 0);
        chk("R4 r0 B", fwd_b, 0);
        quiet(); exmem_rd = 5'd1; exmem_we = 1'b0; memwb_rd = 5'd2; memwb_we = 1'b0; settle();
        chk("R4 we low A", fwd_a, 0);
        chk("R4 we low B", fwd_b, 0);
        quiet(); exmem_rd = 5'd1; exmem_we = 1'b0; memwb_rd = 5'd1; memwb_we = 1'b1; settle();
        chk("R4 dead exmem falls to memwb", fwd_a, 2);
        quiet(); id_rs1 = 5'd0; idex_rd = 5'd0; idex_we = 1'b1; idex_load = 1'b1; settle();
        chk_stall("R4 load to r0 no stall", 0);
        quiet(); id_rs1 = 5'd9; idex_rd = 5'd9; idex_we = 1'b0; idex_load = 1'b1; settle();
        chk_stall("R4 load we low no stall", 0);
    endtask

    task automatic t_bubble();
        quiet(); ex_valid = 1'b0;
        exmem_rd = 5'd1; exmem_we = 1'b1; memwb_rd = 5'd2; memwb_we = 1'b1; settle();
        chk("R6 bubble A", fwd_a, 0);
        chk("R6 bubble B", fwd_b, 0);
    endtask

    task automatic t_load_use();
        quiet(); id_rs1 = 5'd9; idex_rd = 5'd9; idex_we = 1'b1; idex_load = 1'b1; settle();
        chk_stall("R7 load-use rs1", 1);
        quiet(); id_rs2 = 5'd9; idex_rd = 5'd9; idex_we = 1'b1; idex_load = 1'b1; settle();
        chk_stall("R7 load-use rs2", 1);
        quiet(); id_rs1 = 5'd9; idex_rd = 5'd10; idex_we = 1'b1; idex_load = 1'b1; settle();
        chk_stall("R7 load no dependency", 0);
        quiet(); id_rs1 = 5'd9; idex_rd = 5'd9; idex_we = 1'b1; idex_load = 1'b0; settle();
        chk_stall("R8 alu producer no stall", 0);
        quiet(); id_rs1 = 5'd9; id_rs2 = 5'd11;
        exmem_rd = 5'd9; exmem_we = 1'b1; memwb_rd = 5'd11; memwb_we = 1'b1; settle();
        chk_stall("R10 older producers no stall", 0);
    endtask

    task automatic t_sequence();
        // cycle 1: load r9 in EX, dependent (r9 + r3) in ID
        quiet(); id_rs1 = 5'd9; id_rs2 = 5'd3;
        idex_rd = 5'd9; idex_we = 1'b1; idex_load = 1'b1; settle();
        chk_stall("R11 cycle1 stall", 1);
        // cycle 2: bubble in EX, load in MEM, dependent still in ID
        quiet(); id_rs1 = 5'd9; id_rs2 = 5'd3; ex_valid = 1'b0; ex_rs1 = 5'd0; ex_rs2 = 5'd0;
        exmem_rd = 5'd9; exmem_we = 1'b1; settle();
        chk_stall("R11 cycle2 no stall", 0);
        chk("R11 cycle2 bubble A", fwd_a, 0);
        // cycle 3: dependent in EX, bubble in MEM, load in WB
        quiet(); ex_rs1 = 5'd9; ex_rs2 = 5'd3;
        memwb_rd = 5'd9; memwb_we = 1'b1; settle();
        chk("R11 cycle3 dependent A", fwd_a, 2);
        chk("R11 cycle3 B regfile", fwd_b, 0);
        chk_stall("R11 cycle3 no stall", 0);
    endtask

    initial begin
        quiet();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_exmem();
        t_memwb();
        t_priority();
        t_dead_producers();
        t_bubble();
        t_load_use();
        t_sequence();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule